// File: doc/BRIEF.md
# Dual-Channel LED Pattern Sequencer

This block drives a two-bit lamp output from one push button, on a single clock with a synchronous reset. The two lamp bits are timed independently. Each has its own countdown counter, and both take their timing from one clocks-per-millisecond parameter.

Bit 0 is a free-running square wave whose half-periods are not equal. It stays in each level for 10 ms, then 15, 20, 25, 30 and 35 ms. After the 35 ms step it starts again at 10 ms.

Bit 1 is a slow blinker gated by the button. The button is active low and passes through a two-flop synchronizer. Once every 1000 ms the block looks at the synchronized button. If the button is held (low), bit 1 inverts. If the button is released (high), bit 1 is set to 1.

The block has no stream data path, so every pin is a plain control pin with no valid/ready handshake. The clocks-per-millisecond parameter can be lowered so that a simulation runs quickly.

Top module: `dual_led_seq`

## Requirements
- R1: While reset is asserted and on the first edge after it, `lamp` is 2'b00. Reset restarts bit 0 at its 10 ms step, and both countdowns restart with their first delay.
- R2: Counting the first rising edge after reset as edge 1, bit 0 first inverts at edge 10*CLKS_PER_MS. Successive inversions are then spaced 15, 20, 25, 30 and 35 ms apart, where one ms is CLKS_PER_MS edges. Bit 0 never changes between those edges.
- R3: After the 35 ms step, the step sequence wraps to 10 ms and repeats indefinitely.
- R4: Bit 1 changes only at edges k*SLOW_MS*CLKS_PER_MS (k = 1, 2, ...) after reset. Between those edges it holds its value.
- R5: At an evaluation edge, if the synchronized button reads 0 (pressed), bit 1 inverts.
- R6: At an evaluation edge, if the synchronized button reads 1 (released), bit 1 becomes 1, whatever its previous value.
- R7: The evaluation at edge E uses the level that `btn_n` had at edge E-2. A level first present at edge E-1 or later is not seen until the next evaluation. During reset the synchronizer holds the released level (1).
- R8: `lamp[1]` carries the button-gated blinker and `lamp[0]` carries the stepped square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Asynchronous push button, low when pressed |
| lamp | output | 2 | Bit 1: button-gated slow blinker; bit 0: stepped square wave |

## Verification
Each result of this block has a fixed edge, counted from reset release. Bit 0 flips at the running sum of step lengths times CLKS_PER_MS. Bit 1 moves only at multiples of SLOW_MS*CLKS_PER_MS, using the button level registered two edges earlier. The bench keeps its own edge counter and samples on the falling clock after edge E-1 and after edge E for every due change, so a change one cycle early or late is caught. It also drives button changes three and two edges ahead of an evaluation, which pins the synchronizer latency to exactly two flops.

// File: rtl/dual_led_seq_pkg.sv
package dual_led_seq_pkg;

  // clock count of step number idx of the stepped channel
  function automatic int unsigned step_cycles(input int unsigned idx,
                                              input int unsigned first_ms,
                                              input int unsigned inc_ms,
                                              input int unsigned clks_per_ms);
    return (first_ms + idx * inc_ms) * clks_per_ms;
  endfunction

  // bits needed to hold values 0 .. n-1
  function automatic int cnt_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dual_led_seq_sync.sv
module dual_led_seq_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [1:0] chain;

  // reset to the released (high) level so no false press is seen
  always_ff @(posedge clk) begin
    if (rst) chain <= 2'b11;
    else     chain <= {chain[0], din};
  end

  assign dout = chain[1];
endmodule

// File: rtl/dual_led_seq_countdown.sv
module dual_led_seq_countdown #(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] reload_val,
  output logic             expire
);
  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                count <= RST_VAL;
    else if (count == '0)   count <= reload_val;
    else                    count <= count - 1'b1;
  end

  assign expire = (count == '0);
endmodule

// File: rtl/dual_led_seq_pattern.sv
module dual_led_seq_pattern
  import dual_led_seq_pkg::*;
#(
  parameter int NUM_STEPS   = 6,
  parameter int FIRST_MS    = 10,
  parameter int STEP_INC_MS = 5,
  parameter int CLKS_PER_MS = 27000,
  parameter int FAST_W      = 20,
  parameter int IDX_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  output logic [FAST_W-1:0] reload_val,
  output logic [IDX_W-1:0]  step_idx,
  output logic              lamp_q
);
  logic [FAST_W-1:0] reload_tab [NUM_STEPS];
  logic [IDX_W-1:0]  idx_next;

  // one reload constant per step, computed rather than listed
  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    assign reload_tab[g] =
      FAST_W'(step_cycles(g, FIRST_MS, STEP_INC_MS, CLKS_PER_MS) - 1);
  end

  always_comb begin
    if (step_idx == IDX_W'(NUM_STEPS - 1)) idx_next = '0;
    else                                   idx_next = step_idx + 1'b1;
  end

  // the counter reloads in the expiry cycle with the delay of the next step
  assign reload_val = reload_tab[idx_next];

  always_ff @(posedge clk) begin
    if (rst) begin
      step_idx <= '0;
      lamp_q   <= 1'b0;
    end else if (expire) begin
      step_idx <= idx_next;
      lamp_q   <= ~lamp_q;
    end
  end
endmodule

// File: rtl/dual_led_seq.sv
module dual_led_seq
  import dual_led_seq_pkg::*;
#(
  parameter int CLKS_PER_MS = 27000,
  parameter int NUM_STEPS   = 6,
  parameter int FIRST_MS    = 10,
  parameter int STEP_INC_MS = 5,
  parameter int SLOW_MS     = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_n,
  output logic [1:0] lamp
);
  localparam int unsigned FIRST_CYC =
    step_cycles(0, FIRST_MS, STEP_INC_MS, CLKS_PER_MS);
  localparam int unsigned LONGEST_CYC =
    step_cycles(NUM_STEPS - 1, FIRST_MS, STEP_INC_MS, CLKS_PER_MS);
  localparam int unsigned SLOW_CYC = SLOW_MS * CLKS_PER_MS;
  localparam int FAST_W = cnt_width(LONGEST_CYC);
  localparam int SLOW_W = cnt_width(SLOW_CYC);
  localparam int IDX_W  = cnt_width(NUM_STEPS);
  localparam logic [FAST_W-1:0] FAST_FIRST = FAST_W'(FIRST_CYC - 1);
  localparam logic [SLOW_W-1:0] SLOW_LOAD  = SLOW_W'(SLOW_CYC - 1);

  logic              btn_lvl;
  logic              fast_expire;
  logic              slow_expire;
  logic [FAST_W-1:0] fast_reload;
  logic [IDX_W-1:0]  step_idx;
  logic              fast_q;
  logic              slow_q;

  dual_led_seq_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_n),
    .dout (btn_lvl)
  );

  dual_led_seq_countdown #(
    .WIDTH   (FAST_W),
    .RST_VAL (FAST_FIRST)
  ) u_fast_cnt (
    .clk        (clk),
    .rst        (rst),
    .reload_val (fast_reload),
    .expire     (fast_expire)
  );

  dual_led_seq_pattern #(
    .NUM_STEPS   (NUM_STEPS),
    .FIRST_MS    (FIRST_MS),
    .STEP_INC_MS (STEP_INC_MS),
    .CLKS_PER_MS (CLKS_PER_MS),
    .FAST_W      (FAST_W),
    .IDX_W       (IDX_W)
  ) u_pattern (
    .clk        (clk),
    .rst        (rst),
    .expire     (fast_expire),
    .reload_val (fast_reload),
    .step_idx   (step_idx),
    .lamp_q     (fast_q)
  );

  dual_led_seq_countdown #(
    .WIDTH   (SLOW_W),
    .RST_VAL (SLOW_LOAD)
  ) u_slow_cnt (
    .clk        (clk),
    .rst        (rst),
    .reload_val (SLOW_LOAD),
    .expire     (slow_expire)
  );

  // button-gated blinker: pressed (0) inverts, released (1) forces on
  always_ff @(posedge clk) begin
    if (rst)              slow_q <= 1'b0;
    else if (slow_expire) slow_q <= btn_lvl ? 1'b1 : ~slow_q;
  end

  assign lamp = {slow_q, fast_q};
endmodule

// File: rtl/dual_led_seq_chk.sv
module dual_led_seq_chk #(
  parameter int NUM_STEPS = 6,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       lamp,
  input logic             fast_expire,
  input logic             slow_expire,
  input logic             btn_lvl,
  input logic [IDX_W-1:0] step_idx
);
  // R1: reset leaves both lamp bits off and the step pointer at the first step
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (lamp == 2'b00 && step_idx == '0));

  // R2: bit 0 moves only when its countdown expires
  a_r2_fast_holds: assert property (@(posedge clk) disable iff (rst)
    !fast_expire |=> $stable(lamp[0]));

  // R2: bit 0 inverts on every expiry
  a_r2_fast_flips: assert property (@(posedge clk) disable iff (rst)
    fast_expire |=> (lamp[0] != $past(lamp[0])));

  // R3: the last step wraps to the first
  a_r3_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (fast_expire && step_idx == IDX_W'(NUM_STEPS - 1)) |=> (step_idx == '0));

  // R3: the other steps advance by one
  a_r3_step_advances: assert property (@(posedge clk) disable iff (rst)
    (fast_expire && step_idx != IDX_W'(NUM_STEPS - 1))
      |=> (step_idx == IDX_W'($past(step_idx) + 1'b1)));

  // R4: bit 1 holds between evaluations
  a_r4_slow_holds: assert property (@(posedge clk) disable iff (rst)
    !slow_expire |=> $stable(lamp[1]));

  // R5: pressed button inverts bit 1
  a_r5_slow_flips: assert property (@(posedge clk) disable iff (rst)
    (slow_expire && !btn_lvl) |=> (lamp[1] != $past(lamp[1])));

  // R6: released button forces bit 1 on
  a_r6_slow_forced: assert property (@(posedge clk) disable iff (rst)
    (slow_expire && btn_lvl) |=> lamp[1]);
endmodule

bind dual_led_seq dual_led_seq_chk #(
  .NUM_STEPS (NUM_STEPS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lamp        (lamp),
  .fast_expire (fast_expire),
  .slow_expire (slow_expire),
  .btn_lvl     (btn_lvl),
  .step_idx    (step_idx)
);

// File: tb/dual_led_seq_test.sv
`timescale 1ns/1ps
module dual_led_seq_test;
  localparam int CPM    = 4;
  localparam int SLOW_P = 1000 * CPM;
  localparam int ROWS   = 9;
  // stimulus: button level, edges of lead before evaluation; result: bit 1
  localparam int BTN_T  [ROWS] = '{1, 0, 0, 1, 0, 0, 0, 1, 1};
  localparam int LEAD_T [ROWS] = '{50, 50, 50, 3, 2, 50, 50, 2, 50};
  localparam int EXP_T  [ROWS] = '{1, 0, 1, 1, 1, 0, 1, 0, 1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_n = 1'b1;
  logic [1:0] lamp;
  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  dual_led_seq #(.CLKS_PER_MS(CPM)) uut (
    .clk   (clk),
    .rst   (rst),
    .btn_n (btn_n),
    .lamp  (lamp)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // called on a falling edge; returns on the falling edge after edge n
  task automatic wait_edge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int cum;
    int exp0;
    int prev1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", lamp, 0);
    rst = 1'b0;
    wait_edge(1);
    chk("R1 after release", lamp, 0);

    // stepped channel: two full rounds of six steps
    cum = 0;
    exp0 = 0;
    for (int r = 0; r < 12; r++) begin
      cum += (10 + 5 * (r % 6)) * CPM;
      wait_edge(cum - 1);
      chk(r >= 6 ? "R3 hold before flip" : "R2 hold before flip", lamp[0], exp0);
      wait_edge(cum);
      exp0 ^= 1;
      chk(r >= 6 ? "R3 flip after wrap" : "R2 flip", lamp[0], exp0);
      if (r == 0) chk("R8 bit order", lamp, 1);
    end

    // button-gated channel: vector table walked by one loop
    prev1 = 0;
    for (int i = 0; i < ROWS; i++) begin
      int e;
      e = (i + 1) * SLOW_P;
      wait_edge(e - LEAD_T[i]);
      btn_n = BTN_T[i][0];
      wait_edge(e - 1);
      chk("R4 hold before eval", lamp[1], prev1);
      wait_edge(e);
      if (LEAD_T[i] <= 3)  chk("R7 sync latency", lamp[1], EXP_T[i]);
      else if (BTN_T[i] == 0) chk("R5 pressed flips", lamp[1], EXP_T[i]);
      else                 chk("R6 released forces", lamp[1], EXP_T[i]);
      prev1 = EXP_T[i];
    end

    // reset in mid run restarts the stepped sequence at 10 ms
    rst = 1'b1;
    btn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mid-run reset", lamp, 0);
    rst = 1'b0;
    wait_edge(1);
    chk("R1 after second release", lamp, 0);
    wait_edge(10 * CPM - 1);
    chk("R1 restart hold", lamp[0], 0);
    wait_edge(10 * CPM);
    chk("R1 restart first step", lamp[0], 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule